// File: doc/BRIEF.md
# Character display command engine

This block executes the instruction set of a two-line character display controller. The bus side hands it one tagged byte at a time: a register-select tag (instruction or data), a read/write tag and the byte itself. The engine decodes instructions and keeps the display configuration. It moves a single 7-bit address counter across two internal arrays, an 80-byte display RAM and a 64-byte pattern RAM. It also tracks a horizontal display shift offset.

Every accepted operation makes the engine busy for a parameterised number of cycles. A status read is answered at any time and returns the busy flag with the address counter. Any other access that arrives while the engine is busy is dropped. Data reads come from a prefetch register, which is loaded from RAM when an address is set and after each read. The first data read that follows any other operation therefore returns stale data.

The control is one state machine with four states:
- ST_BOOT_FILL: after reset, writes the blank code into every display slot.
- ST_CLR_FILL: does the same for a clear instruction.
- ST_HOLD: counts down the busy time of the current operation.
- ST_IDLE: accepts work.

Its transitions are:
- reset → ST_BOOT_FILL.
- ST_BOOT_FILL → ST_HOLD, after the last slot, loading T_INIT.
- ST_IDLE → ST_CLR_FILL, on an accepted clear.
- ST_CLR_FILL → ST_HOLD, after the last slot, loading T_LONG.
- ST_IDLE → ST_HOLD, on any other accepted operation, loading T_SHORT, or T_LONG for home.
- ST_HOLD → ST_IDLE, when the count reaches zero.

A byte of 0x00 is not an instruction. It leaves the engine idle.

Top module: `chr_cmd_engine`

## Requirements
- R1: An instruction byte is classified by its highest set bit. Bit 7 is set display address (bits 6:0). Bit 6 is set pattern address (bits 5:0). Bit 5 is function set (bit 4 wide bus, bit 3 two lines, bit 2 tall font). Bit 4 is shift (bit 3 display/cursor, bit 2 right). Bit 3 is display control (bit 2 display, bit 1 cursor, bit 0 blink). Bit 2 is entry mode (bit 1 increment, bit 0 shift on write). Bit 1 is home, and bit 0 is don't-care for it. Bit 0 alone is clear.
- R2: Clear writes 0x20 into all 80 display slots, sets the address counter to 0, selects display RAM and sets the shift offset to 0.
- R3: Home sets the address counter to 0, selects display RAM and sets the shift offset to 0. RAM contents are left unchanged.
- R4: Each data read or write steps the address counter by +1 when the increment bit is 1 and by -1 when it is 0. This holds in display RAM and in pattern RAM. Pattern RAM addresses wrap modulo 64.
- R5: The display-RAM address counter wraps in both directions. In two-line mode 0x27 goes to 0x40 and 0x67 goes to 0x00. In one-line mode 0x4F goes to 0x00. Display address 0x40+n maps to slot 40+n in two-line mode.
- R6: With shift-on-write set, each data write moves the offset: +1 (left) when incrementing and -1 (right) when decrementing. Data reads never change the offset.
- R7: The shift instruction with bit 3 clear steps only the address counter, right when bit 2 is 1 and left when it is 0. With bit 3 set it moves the offset instead, +1 for left and -1 for right. The offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode.
- R8: The display control and function set fields drive the configuration outputs. A function set also returns the shift offset to 0.
- R9: A status read (tag instruction, read) is served in every state. On the next cycle rd_data holds the busy flag in bit 7 and the address counter in bits 6:0. Every other access made while busy is ignored.
- R10: Setting either address loads the prefetch register from the new location. A data read returns the prefetch register, steps the counter and reloads the register from the new location. After a data write, the next read returns the value prefetched before the write.
- R11: Busy lasts T_SHORT cycles for data accesses and most instructions, T_LONG for home, and 80 + T_LONG for clear.
- R12: Reset selects wide bus, one line, small font, display, cursor and blink off, increment with no shift, offset 0 and address 0. Busy then stays high for 80 + T_INIT cycles while display RAM is filled with 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts power-on sequence |
| bus_valid | input | 1 | A byte is presented this cycle |
| bus_rs | input | 1 | 1 = data access, 0 = instruction/status |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Instruction or data byte |
| rd_data | output | 8 | Result of the last status or data read |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor visible |
| blink_on | output | 1 | Character blink at cursor |
| two_line | output | 1 | Two-line addressing mode |
| tall_font | output | 1 | Tall font selected |
| wide_bus | output | 1 | Full-byte bus width selected |
| shift_ofs | output | 7 | Display shift offset |

## Verification
The bench builds the engine with T_SHORT=3, T_LONG=10 and T_INIT=20, and keeps the 80/64-byte RAMs and 40-column lines. The short counts keep busy-time checks exact: 100 busy reads after reset, 90 after a clear, 10 after home and 3 after a short operation. They also leave room to walk both line wraps, the one-line wrap, the offset wrap at 39 and 79, and the stale prefetch read. Exact busy counts also make it possible to drop an instruction into the middle of a busy window and then observe that it had no effect.

// File: rtl/chr_pkg.sv
package chr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BOOT_FILL,
        ST_CLR_FILL,
        ST_HOLD
    } eng_state_t;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGA,
        OP_DDA
    } op_t;

    localparam logic [7:0] BLANK_CODE = 8'h20;

    // Map a 7-bit display address onto a linear RAM slot.
    function automatic logic [6:0] dd_slot(input logic [6:0] a,
                                           input logic two,
                                           input logic [6:0] line_len);
        if (!two)
            return a;
        else if (a[6])
            return line_len + {1'b0, a[5:0]};
        else
            return {1'b0, a[5:0]};
    endfunction

endpackage

// File: rtl/chr_op_decode.sv
module chr_op_decode
    import chr_pkg::*;
(
    input  logic [7:0] code,
    output op_t        op
);
    always_comb begin
        if (code[7])      op = OP_DDA;
        else if (code[6]) op = OP_CGA;
        else if (code[5]) op = OP_FUNC;
        else if (code[4]) op = OP_SHIFT;
        else if (code[3]) op = OP_DISP;
        else if (code[2]) op = OP_ENTRY;
        else if (code[1]) op = OP_HOME;
        else if (code[0]) op = OP_CLEAR;
        else              op = OP_NOP;
    end
endmodule

// File: rtl/chr_ac_step.sv
module chr_ac_step #(
    parameter int LINE_LEN = 40,
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64
) (
    input  logic [6:0] ac,
    input  logic       up,
    input  logic       two_line,
    input  logic       in_cg,
    output logic [6:0] ac_nxt
);
    localparam logic [6:0] CG_LAST  = 7'(CG_DEPTH - 1);
    localparam logic [6:0] DD_LAST  = 7'(DD_DEPTH - 1);
    localparam logic [6:0] L1_LAST  = 7'(LINE_LEN - 1);
    localparam logic [6:0] L2_FIRST = 7'h40;
    localparam logic [6:0] L2_LAST  = 7'(64 + LINE_LEN - 1);

    always_comb begin
        if (in_cg) begin
            if (up) ac_nxt = (ac >= CG_LAST) ? 7'd0 : ac + 7'd1;
            else    ac_nxt = (ac == 7'd0) ? CG_LAST : ac - 7'd1;
        end else if (two_line) begin
            if (up) begin
                if (ac == L1_LAST)      ac_nxt = L2_FIRST;
                else if (ac >= L2_LAST) ac_nxt = 7'd0;
                else                    ac_nxt = ac + 7'd1;
            end else begin
                if (ac == L2_FIRST)     ac_nxt = L1_LAST;
                else if (ac == 7'd0)    ac_nxt = L2_LAST;
                else                    ac_nxt = ac - 7'd1;
            end
        end else begin
            if (up) ac_nxt = (ac >= DD_LAST) ? 7'd0 : ac + 7'd1;
            else    ac_nxt = (ac == 7'd0) ? DD_LAST : ac - 7'd1;
        end
    end
endmodule

// File: rtl/chr_ofs_step.sv
module chr_ofs_step #(
    parameter int LINE_LEN = 40,
    parameter int DD_DEPTH = 80
) (
    input  logic [6:0] ofs,
    input  logic       left,
    input  logic       two_line,
    output logic [6:0] ofs_nxt
);
    logic [6:0] lim_last;

    always_comb begin
        lim_last = two_line ? 7'(LINE_LEN - 1) : 7'(DD_DEPTH - 1);
        if (left)
            ofs_nxt = (ofs >= lim_last) ? 7'd0 : ofs + 7'd1;
        else
            ofs_nxt = (ofs == 7'd0 || ofs > lim_last) ? lim_last : ofs - 7'd1;
    end
endmodule

// File: rtl/chr_byte_ram.sv
module chr_byte_ram #(
    parameter int DEPTH = 80,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(wa) < DEPTH))
            mem[wa] <= wd;
    end

    assign rd = (32'(ra) < DEPTH) ? mem[ra] : 8'h00;
endmodule

// File: rtl/chr_cmd_engine.sv
module chr_cmd_engine
    import chr_pkg::*;
#(
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64,
    parameter int LINE_LEN = 40,
    parameter int T_SHORT  = 4,
    parameter int T_LONG   = 16,
    parameter int T_INIT   = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       bus_rs,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] rd_data,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       two_line,
    output logic       tall_font,
    output logic       wide_bus,
    output logic [6:0] shift_ofs
);
    localparam int TMAX_A = (T_INIT > T_LONG) ? T_INIT : T_LONG;
    localparam int TMAX   = (TMAX_A > T_SHORT) ? TMAX_A : T_SHORT;
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int CG_AW  = $clog2(CG_DEPTH);
    localparam logic [6:0] DD_LAST = 7'(DD_DEPTH - 1);
    localparam logic [6:0] LLEN    = 7'(LINE_LEN);

    eng_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [6:0]       fill_idx;
    logic [6:0]       ac, ac_n, ac_step;
    logic             sel_cg, sel_n;
    logic [6:0]       ofs, ofs_n, ofs_step;
    logic [7:0]       rbuf;
    logic             inc_mode, shift_wr;
    logic             pf_load;
    logic             eng_busy;
    logic             accept, is_stat, is_shift_ins;
    logic             step_up, ofs_left;
    op_t              op;

    logic             dd_we, cg_we;
    logic [6:0]       dd_wa, dd_ra;
    logic [7:0]       dd_wd, dd_rd, cg_rd;
    logic [CG_AW-1:0] cg_wa, cg_ra;

    assign eng_busy     = (state != ST_IDLE);
    assign is_stat      = bus_valid && !bus_rs && bus_rd;
    assign accept       = (state == ST_IDLE) && bus_valid && !is_stat;
    assign is_shift_ins = accept && !bus_rs && (op == OP_SHIFT);
    assign step_up      = is_shift_ins ? bus_wdata[2] : inc_mode;
    assign ofs_left     = is_shift_ins ? !bus_wdata[2] : inc_mode;

    chr_op_decode u_dec (.code(bus_wdata), .op(op));

    chr_ac_step #(.LINE_LEN(LINE_LEN), .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_acs (
        .ac(ac), .up(step_up), .two_line(two_line), .in_cg(sel_cg), .ac_nxt(ac_step)
    );

    chr_ofs_step #(.LINE_LEN(LINE_LEN), .DD_DEPTH(DD_DEPTH)) u_ofs (
        .ofs(ofs), .left(ofs_left), .two_line(two_line), .ofs_nxt(ofs_step)
    );

    chr_byte_ram #(.DEPTH(DD_DEPTH), .AW(7)) u_dd (
        .clk(clk), .we(dd_we), .wa(dd_wa), .wd(dd_wd), .ra(dd_ra), .rd(dd_rd)
    );

    chr_byte_ram #(.DEPTH(CG_DEPTH), .AW(CG_AW)) u_cg (
        .clk(clk), .we(cg_we), .wa(cg_wa), .wd(bus_wdata), .ra(cg_ra), .rd(cg_rd)
    );

    assign dd_ra = dd_slot(ac_n, two_line, LLEN);
    assign cg_ra = ac_n[CG_AW-1:0];
    assign cg_wa = ac[CG_AW-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT_FILL;
        else        state <= state_n;
    end

    // Next state and per-cycle control
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        ac_n    = ac;
        sel_n   = sel_cg;
        ofs_n   = ofs;
        pf_load = 1'b0;
        dd_we   = 1'b0;
        dd_wa   = dd_slot(ac, two_line, LLEN);
        dd_wd   = bus_wdata;
        cg_we   = 1'b0;
        unique case (state)
            ST_BOOT_FILL, ST_CLR_FILL: begin
                dd_we = 1'b1;
                dd_wa = fill_idx;
                dd_wd = BLANK_CODE;
                if (fill_idx == DD_LAST) begin
                    state_n = ST_HOLD;
                    cnt_n   = (state == ST_BOOT_FILL) ? CNT_W'(T_INIT - 1)
                                                      : CNT_W'(T_LONG - 1);
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            ST_IDLE: begin
                if (accept) begin
                    state_n = ST_HOLD;
                    cnt_n   = CNT_W'(T_SHORT - 1);
                    if (bus_rs) begin
                        ac_n = ac_step;
                        if (bus_rd) begin
                            pf_load = 1'b1;
                        end else begin
                            dd_we = !sel_cg;
                            cg_we = sel_cg;
                            if (shift_wr) ofs_n = ofs_step;
                        end
                    end else begin
                        case (op)
                            OP_CLEAR: begin
                                state_n = ST_CLR_FILL;
                                ac_n    = 7'd0;
                                sel_n   = 1'b0;
                                ofs_n   = 7'd0;
                            end
                            OP_HOME: begin
                                cnt_n = CNT_W'(T_LONG - 1);
                                ac_n  = 7'd0;
                                sel_n = 1'b0;
                                ofs_n = 7'd0;
                            end
                            OP_SHIFT: begin
                                if (bus_wdata[3]) ofs_n = ofs_step;
                                else              ac_n  = ac_step;
                            end
                            OP_FUNC: ofs_n = 7'd0;
                            OP_CGA: begin
                                ac_n    = {1'b0, bus_wdata[5:0]};
                                sel_n   = 1'b1;
                                pf_load = 1'b1;
                            end
                            OP_DDA: begin
                                ac_n    = bus_wdata[6:0];
                                sel_n   = 1'b0;
                                pf_load = 1'b1;
                            end
                            OP_NOP: begin
                                state_n = ST_IDLE;
                                cnt_n   = cnt;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            fill_idx  <= 7'd0;
            ac        <= 7'd0;
            sel_cg    <= 1'b0;
            ofs       <= 7'd0;
            rbuf      <= BLANK_CODE;
            rd_data   <= 8'h00;
            inc_mode  <= 1'b1;
            shift_wr  <= 1'b0;
            disp_on   <= 1'b0;
            cursor_on <= 1'b0;
            blink_on  <= 1'b0;
            two_line  <= 1'b0;
            tall_font <= 1'b0;
            wide_bus  <= 1'b1;
        end else begin
            cnt    <= cnt_n;
            ac     <= ac_n;
            sel_cg <= sel_n;
            ofs    <= ofs_n;
            if ((state == ST_BOOT_FILL || state == ST_CLR_FILL) && fill_idx != DD_LAST)
                fill_idx <= fill_idx + 7'd1;
            else
                fill_idx <= 7'd0;
            if (pf_load)
                rbuf <= sel_n ? cg_rd : dd_rd;
            if (is_stat)
                rd_data <= {eng_busy, ac};
            else if (accept && bus_rs && bus_rd)
                rd_data <= rbuf;
            if (accept && !bus_rs) begin
                case (op)
                    OP_ENTRY: begin
                        inc_mode <= bus_wdata[1];
                        shift_wr <= bus_wdata[0];
                    end
                    OP_DISP: begin
                        disp_on   <= bus_wdata[2];
                        cursor_on <= bus_wdata[1];
                        blink_on  <= bus_wdata[0];
                    end
                    OP_FUNC: begin
                        wide_bus  <= bus_wdata[4];
                        two_line  <= bus_wdata[3];
                        tall_font <= bus_wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign shift_ofs = ofs;
endmodule

// File: rtl/chr_cmd_engine_chk.sv
module chr_cmd_engine_chk #(
    parameter int LINE_LEN = 40,
    parameter int DD_DEPTH = 80
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_rs,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       disp_on,
    input logic       two_line,
    input logic [6:0] shift_ofs
);
    assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_rs && bus_rd) |=> (rd_data[7] == $past(busy)));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_valid && !bus_rs && !bus_rd) |=> $stable(disp_on));

    assert_read_noshift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_rs && bus_rd) |=> $stable(shift_ofs));

    assert_clear_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_valid && !bus_rs && !bus_rd && bus_wdata == 8'h01)
        |=> (shift_ofs == 7'd0 && busy));

    assert_ofs_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(shift_ofs) < (two_line ? LINE_LEN : DD_DEPTH));
endmodule

bind chr_cmd_engine chr_cmd_engine_chk #(.LINE_LEN(LINE_LEN), .DD_DEPTH(DD_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .busy(eng_busy), .disp_on(disp_on),
    .two_line(two_line), .shift_ofs(shift_ofs)
);

// File: tb/chr_cmd_engine_bench.sv
module chr_cmd_engine_bench;
    localparam int T_SHORT = 3;
    localparam int T_LONG  = 10;
    localparam int T_INIT  = 20;
    localparam int DD      = 80;

    // kind: 0 instruction, 1 data write, 2 data read (check), 3 status AC (check)
    localparam int NV = 52;
    localparam logic [21:0] VEC [NV] = '{
        {4'd8,  2'd0, 8'h38, 8'h00}, // R8 two-line
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd4,  2'd1, 8'h41, 8'h00},
        {4'd4,  2'd1, 8'h42, 8'h00},
        {4'd4,  2'd3, 8'h00, 8'h02}, // R4 increment
        {4'd1,  2'd0, 8'hA7, 8'h00},
        {4'd5,  2'd1, 8'h43, 8'h00},
        {4'd5,  2'd3, 8'h00, 8'h40}, // R5 0x27 -> 0x40
        {4'd5,  2'd1, 8'h44, 8'h00},
        {4'd10, 2'd0, 8'h80, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h41}, // R10 prefetch on set
        {4'd4,  2'd2, 8'h00, 8'h42}, // R4
        {4'd1,  2'd0, 8'h04, 8'h00}, // R1 entry: decrement
        {4'd1,  2'd0, 8'hC0, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h44},
        {4'd5,  2'd3, 8'h00, 8'h27}, // R5 0x40 -> 0x27
        {4'd4,  2'd2, 8'h00, 8'h43},
        {4'd4,  2'd3, 8'h00, 8'h26},
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h41},
        {4'd5,  2'd3, 8'h00, 8'h67}, // R5 0x00 -> 0x67
        {4'd1,  2'd0, 8'h06, 8'h00},
        {4'd1,  2'd0, 8'h48, 8'h00}, // pattern address 8
        {4'd4,  2'd1, 8'h1F, 8'h00},
        {4'd4,  2'd1, 8'h0A, 8'h00},
        {4'd4,  2'd1, 8'h11, 8'h00},
        {4'd4,  2'd3, 8'h00, 8'h0B}, // R4 pattern RAM stepping
        {4'd1,  2'd0, 8'h48, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h1F},
        {4'd4,  2'd2, 8'h00, 8'h0A},
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd10, 2'd1, 8'h50, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h41}, // R10 stale read after write
        {4'd10, 2'd2, 8'h00, 8'h20},
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd10, 2'd2, 8'h00, 8'h50},
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd7,  2'd0, 8'h10, 8'h00}, // cursor left
        {4'd7,  2'd3, 8'h00, 8'h67}, // R7
        {4'd7,  2'd0, 8'h14, 8'h00}, // cursor right
        {4'd7,  2'd3, 8'h00, 8'h00}, // R7
        {4'd1,  2'd0, 8'hC5, 8'h00},
        {4'd3,  2'd0, 8'h03, 8'h00}, // R1 home, bit0 don't care
        {4'd3,  2'd3, 8'h00, 8'h00}, // R3
        {4'd1,  2'd0, 8'h80, 8'h00},
        {4'd3,  2'd2, 8'h00, 8'h50}, // R3 RAM kept
        {4'd8,  2'd0, 8'h30, 8'h00}, // one-line
        {4'd1,  2'd0, 8'hCF, 8'h00},
        {4'd5,  2'd1, 8'h45, 8'h00},
        {4'd5,  2'd3, 8'h00, 8'h00}, // R5 0x4F -> 0x00
        {4'd5,  2'd0, 8'h10, 8'h00},
        {4'd5,  2'd3, 8'h00, 8'h4F}  // R5 0x00 -> 0x4F
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_rs = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       disp_on, cursor_on, blink_on, two_line, tall_font, wide_bus;
    logic [6:0] shift_ofs;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    chr_cmd_engine #(.T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_INIT(T_INIT)) u_chr_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .two_line(two_line), .tall_font(tall_font), .wide_bus(wide_bus),
        .shift_ofs(shift_ofs)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Starts and ends at a falling edge; one cycle on the bus.
    task automatic op(input logic rs, input logic rd, input logic [7:0] b);
        bus_valid = 1'b1; bus_rs = rs; bus_rd = rd; bus_wdata = b;
        @(negedge clk);
        bus_valid = 1'b0; bus_rs = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            op(1'b0, 1'b1, 8'h00);
            if (rd_data[7]) n++;
            else break;
        end
    endtask

    task automatic ins(input logic [7:0] b);
        int n;
        op(1'b0, 1'b0, b);
        count_busy(n);
    endtask

    task automatic wr(input logic [7:0] b);
        int n;
        op(1'b1, 1'b0, b);
        count_busy(n);
    endtask

    task automatic rdd(output logic [7:0] v);
        int n;
        op(1'b1, 1'b1, 8'h00);
        v = rd_data;
        count_busy(n);
    endtask

    task automatic stat(output logic [7:0] v);
        op(1'b0, 1'b1, 8'h00);
        v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 power-on busy window and reset state
        count_busy(n);
        check("R12 boot busy cycles", n, DD + T_INIT);
        check("R12 disp_on", disp_on, 0);
        check("R12 cursor_on", cursor_on, 0);
        check("R12 blink_on", blink_on, 0);
        check("R12 two_line", two_line, 0);
        check("R12 tall_font", tall_font, 0);
        check("R12 wide_bus", wide_bus, 1);
        check("R12 shift_ofs", shift_ofs, 0);
        stat(v);
        check("R12 address", v, 0);
        ins(8'h85);
        rdd(v);
        check("R12 filled blank", v, 8'h20);
        stat(v);
        check("R12 increment default", v, 8'h06);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VEC[i][21:18], i);
            case (VEC[i][17:16])
                2'd0: ins(VEC[i][15:8]);
                2'd1: wr(VEC[i][15:8]);
                2'd2: begin rdd(v); check(tag, v, VEC[i][7:0]); end
                default: begin stat(v); check(tag, v, VEC[i][7:0]); end
            endcase
        end

        // R8 configuration fields
        ins(8'h0D);
        check("R8 disp_on", disp_on, 1);
        check("R8 cursor_on", cursor_on, 0);
        check("R8 blink_on", blink_on, 1);
        ins(8'h24);
        check("R8 wide_bus", wide_bus, 0);
        check("R8 tall_font", tall_font, 1);
        check("R8 two_line", two_line, 0);

        // R7 display shift wrap
        ins(8'h38);
        ins(8'h1C);
        check("R7 right wrap two-line", shift_ofs, 39);
        ins(8'h18);
        check("R7 left wrap", shift_ofs, 0);
        ins(8'h18);
        check("R7 left step", shift_ofs, 1);
        ins(8'h30);
        check("R8 function set cancels shift", shift_ofs, 0);
        ins(8'h1C);
        check("R7 right wrap one-line", shift_ofs, 79);

        // R6 shift on write, none on read
        ins(8'h38);
        ins(8'h07);
        ins(8'h80);
        wr(8'h55);
        check("R6 write shifts left", shift_ofs, 1);
        rdd(v);
        check("R6 read no shift", shift_ofs, 1);
        ins(8'h05);
        wr(8'h56);
        check("R6 write shifts right", shift_ofs, 0);
        wr(8'h57);
        check("R6 right wrap", shift_ofs, 39);

        // R2 / R11 clear
        op(1'b0, 1'b0, 8'h01);
        count_busy(n);
        check("R11 clear busy cycles", n, DD + T_LONG);
        check("R2 clear offset", shift_ofs, 0);
        stat(v);
        check("R2 clear address", v, 0);
        ins(8'h80);
        rdd(v);
        check("R2 slot 0 blank", v, 8'h20);
        ins(8'hC0);
        rdd(v);
        check("R2 slot 40 blank", v, 8'h20);

        // R11 busy durations
        op(1'b0, 1'b0, 8'h08);
        count_busy(n);
        check("R11 short busy", n, T_SHORT);
        op(1'b0, 1'b0, 8'h02);
        count_busy(n);
        check("R11 home busy", n, T_LONG);
        op(1'b1, 1'b0, 8'h33);
        count_busy(n);
        check("R11 data busy", n, T_SHORT);

        // R9 instruction ignored while busy
        ins(8'h0C);
        op(1'b0, 1'b0, 8'h08);
        op(1'b0, 1'b0, 8'h0F);
        count_busy(n);
        check("R9 ignored disp_on", disp_on, 0);
        check("R9 ignored cursor_on", cursor_on, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule